// File: doc/BRIEF.md
# Serial Mode Controller with Power-Fail Flag

This block is the serial front end of a multi-channel acquisition device. Traffic is framed by an active-low chip select and a serial clock, all sampled in the oscillator clock domain. Each frame is one of two kinds. A read frame shifts the 16-bit limit status and a sticky power-fail flag out on the data output. An input frame shifts in a 16-bit word. The word carries a 4-bit mode code followed by a 12-bit channel-pair configuration.

After reset the controller sits in watchdog mode with the power-fail flag set. It raises its interrupt once chip select is first seen high. While in watchdog mode, the length of the chip-select-high gap before a falling edge picks the frame type. A short gap opens an input frame, so that software can change mode. A long gap opens another status read. The limit scanner is outside this block. It hands status over through a load strobe, and it takes the mode and the decoded per-pair channel enables from the output ports.

Top module: `msc_top`

## Requirements
- R1: After reset the mode is watchdog (code 0xA), the configuration is zero, the power-fail flag is 1 and a status interrupt is pending. irq_n_o stays high until cs_n_i has been sampled high at least once, and then goes low.
- R2: In watchdog mode, a read frame drives 17 bits on do_o with the most significant bit first: status bit 15 down to status bit 0, then the power-fail flag. The first bit is valid once the chip-select fall has been sampled, and each later bit follows a falling serial clock edge.
- R3: The 17th rising serial clock edge of a read frame clears the status register and releases the interrupt (irq_n_o goes high).
- R4: A one-cycle stat_load_i pulse captures stat_i as the status and makes the interrupt pending.
- R5: In watchdog mode, a chip-select fall that follows fewer than HOLD_MAX (32) oscillator cycles of cs_n_i high opens an input frame. A longer gap opens a read frame, and DI has no effect during that frame. In any other mode, every frame is an input frame.
- R6: An input frame samples di_i on rising serial clock edges, most significant bit first. Word bits 15:12 are the mode code and bits 11:0 are the configuration. The word takes effect on the 16th rising edge. A frame that ends before 16 bits changes nothing.
- R7: The defined mode codes are 0xA (watchdog), 0x5 (auto scan) and 0x3 (single conversion). Any other code leaves both the mode and the configuration unchanged.
- R8: Codes 0xA and 0x5 store the 12-bit configuration. Code 0x3 keeps the stored configuration.
- R9: A committed word whose mode differs from the current mode clears the power-fail flag. Rewriting the current mode leaves the flag unchanged.
- R10: Configuration group g (bits 3g+2:3g) controls channels 2g and 2g+1. Field bits 2:1 select the use: 00 both channels off, 01 both single-ended, 10 differential pair with bit 0 swapping polarity, 11 one single-ended channel, where bit 0 = 1 picks the upper channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n_i | input | 1 | Active-low chip select framing each transfer |
| sclk_i | input | 1 | Serial clock, sampled in the clk domain |
| di_i | input | 1 | Serial data in |
| do_o | output | 1 | Serial data out (status then power-fail flag) |
| irq_n_o | output | 1 | Active-low interrupt |
| stat_load_i | input | 1 | Strobe from the scanner to capture stat_i |
| stat_i | input | STAT_W | Status bits from the scanner |
| mode_o | output | 4 | Current mode code |
| cfg_o | output | PAIRS*3 | Stored channel configuration |
| chan_en_o | output | 2*PAIRS | Per-channel enable |
| pair_diff_o | output | PAIRS | Pair runs in differential mode |
| pair_swap_o | output | PAIRS | Differential pair with swapped polarity |

## Verification
A vector table of input words walks the controller through every defined mode code, one undefined code, and the single-conversion code that must keep the old configuration. The results separate "mode changed" from "configuration changed". Its configuration values cover all four uses of a channel pair and both settings of the select bit, so a swapped group or a wrong channel order shows up as a wrong enable or polarity vector. Status reads use an asymmetric pattern (0xA5C3) with DI held high, which exposes bit-order errors and any leak of DI into a read frame. Short and long chip-select gaps, a truncated frame and a same-mode rewrite after a fresh reset separate the exit timing, the commit point and the sticky power-fail behaviour.

// File: rtl/msc_pkg.sv
// Shared definitions for the serial mode controller.
// Assumes: mode codes are 4 bits wide and travel at the front of every input word.
package msc_pkg;
    localparam int MODE_W = 4;
    localparam int GRP_W  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_SINGLE = 4'h3,
        MODE_AUTO   = 4'h5,
        MODE_WATCH  = 4'hA
    } mode_e;

    // True when the code names a supported operating mode.
    function automatic logic mode_known(input logic [MODE_W-1:0] code);
        return (code == MODE_SINGLE) || (code == MODE_AUTO) || (code == MODE_WATCH);
    endfunction

    // True when the mode carries a channel configuration with it.
    function automatic logic mode_takes_cfg(input logic [MODE_W-1:0] code);
        return (code == MODE_AUTO) || (code == MODE_WATCH);
    endfunction
endpackage

// File: rtl/msc_cs_timer.sv
// Measures how long chip select has been high, in oscillator cycles, saturating at HOLD_MAX.
// Assumes: cs_n_i is already synchronous to clk. After reset the gap counts as long,
// so the first frame after power-up is never taken as an exit request.
module msc_cs_timer #(
    parameter int HOLD_MAX = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_i,
    output logic short_o
);
    localparam int CW = $clog2(HOLD_MAX + 1);
    localparam logic [CW-1:0] CMAX = CW'(HOLD_MAX);

    logic [CW-1:0] hi_cnt;

    // Count the high time; clear it while chip select is low.
    always_ff @(posedge clk) begin
        if (!rst_n)           hi_cnt <= CMAX;
        else if (!cs_n_i)     hi_cnt <= '0;
        else if (hi_cnt != CMAX) hi_cnt <= hi_cnt + 1'b1;
    end

    assign short_o = (hi_cnt < CMAX);
endmodule

// File: rtl/msc_out_shift.sv
// Parallel-load, MSB-first output shifter for the status read stream.
// Assumes: load and shift never happen in the same cycle (the framing logic keeps them apart).
module msc_out_shift #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    input  logic         shift_i,
    output logic         bit_o
);
    logic [W-1:0] sh;

    // Capture the stream at frame start and advance it one bit per falling serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       sh <= '0;
        else if (load_i)  sh <= data_i;
        else if (shift_i) sh <= {sh[W-2:0], 1'b0};
    end

    assign bit_o = sh[W-1];
endmodule

// File: rtl/msc_chan_decode.sv
// Turns the packed per-pair configuration into channel enables and differential controls.
// Assumes: field bits 2:1 select the use and bit 0 picks the channel or the polarity.
module msc_chan_decode
    import msc_pkg::*;
#(
    parameter int PAIRS = 4
) (
    input  logic [PAIRS*GRP_W-1:0] cfg_i,
    output logic [2*PAIRS-1:0]     en_o,
    output logic [PAIRS-1:0]       diff_o,
    output logic [PAIRS-1:0]       swap_o
);
    for (genvar g = 0; g < PAIRS; g++) begin : g_pair
        logic [GRP_W-1:0] fld;
        assign fld = cfg_i[g*GRP_W +: GRP_W];

        // Decode one pair's field.
        always_comb begin
            en_o[2*g +: 2] = 2'b00;
            diff_o[g]      = 1'b0;
            swap_o[g]      = 1'b0;
            unique case (fld[2:1])
                2'b00: en_o[2*g +: 2] = 2'b00;
                2'b01: en_o[2*g +: 2] = 2'b11;
                2'b10: begin
                    en_o[2*g +: 2] = 2'b11;
                    diff_o[g]      = 1'b1;
                    swap_o[g]      = fld[0];
                end
                default: en_o[2*g +: 2] = fld[0] ? 2'b10 : 2'b01;
            endcase
        end
    end
endmodule

// File: rtl/msc_top.sv
// Serial mode controller: frames transfers with chip select, writes mode and configuration
// words, streams the watchdog status with the power-fail flag, and raises the interrupt.
// Assumes: cs_n_i, sclk_i and di_i are synchronous to clk, and each serial clock phase
// lasts at least one clk cycle.
module msc_top
    import msc_pkg::*;
#(
    parameter int STAT_W   = 16,
    parameter int PAIRS    = 4,
    parameter int HOLD_MAX = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cs_n_i,
    input  logic                   sclk_i,
    input  logic                   di_i,
    output logic                   do_o,
    output logic                   irq_n_o,
    input  logic                   stat_load_i,
    input  logic [STAT_W-1:0]      stat_i,
    output logic [MODE_W-1:0]      mode_o,
    output logic [PAIRS*GRP_W-1:0] cfg_o,
    output logic [2*PAIRS-1:0]     chan_en_o,
    output logic [PAIRS-1:0]       pair_diff_o,
    output logic [PAIRS-1:0]       pair_swap_o
);
    localparam int CFG_W  = PAIRS * GRP_W;
    localparam int WORD_W = MODE_W + CFG_W;
    localparam int RD_W   = STAT_W + 1;
    localparam int MAXB   = (WORD_W > RD_W) ? WORD_W : RD_W;
    localparam int CNT_W  = $clog2(MAXB + 1);

    logic              cs_q, sclk_q, cs_seen;
    logic              frame_rd, frame_wr;
    logic [CNT_W-1:0]  bit_cnt;
    logic [WORD_W-2:0] in_word;
    logic [WORD_W-1:0] next_word;
    mode_e             mode_q;
    logic [CFG_W-1:0]  cfg_q;
    logic              pf_q, irq_pend;
    logic [STAT_W-1:0] stat_q;
    logic              short_gap, cs_fall, sclk_rise, sclk_fall;
    logic              start_rd, wr_done, rd_done, sh_bit;
    logic [MODE_W-1:0] new_mode;

    assign cs_fall   = cs_q & ~cs_n_i;
    assign sclk_rise = sclk_i & ~sclk_q;
    assign sclk_fall = ~sclk_i & sclk_q;
    assign start_rd  = cs_fall & (mode_q == MODE_WATCH) & ~short_gap;
    assign next_word = {in_word, di_i};
    assign new_mode  = next_word[WORD_W-1 -: MODE_W];
    assign wr_done   = frame_wr & ~cs_n_i & sclk_rise & (bit_cnt == CNT_W'(WORD_W - 1));
    assign rd_done   = frame_rd & ~cs_n_i & sclk_rise & (bit_cnt == CNT_W'(RD_W - 1));

    msc_cs_timer #(.HOLD_MAX(HOLD_MAX)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_i  (cs_n_i),
        .short_o (short_gap)
    );

    msc_out_shift #(.W(RD_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (start_rd),
        .data_i  ({stat_q, pf_q}),
        .shift_i (frame_rd & ~cs_n_i & sclk_fall),
        .bit_o   (sh_bit)
    );

    msc_chan_decode #(.PAIRS(PAIRS)) u_dec (
        .cfg_i  (cfg_q),
        .en_o   (chan_en_o),
        .diff_o (pair_diff_o),
        .swap_o (pair_swap_o)
    );

    // Edge-detect history for chip select and serial clock; remember the first high chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= 1'b0;
            sclk_q  <= 1'b0;
            cs_seen <= 1'b0;
        end else begin
            cs_q   <= cs_n_i;
            sclk_q <= sclk_i;
            if (cs_n_i) cs_seen <= 1'b1;
        end
    end

    // Frame type and bit counter, opened at a chip-select fall and closed by chip select or the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_n_i) begin
            frame_rd <= 1'b0;
            frame_wr <= 1'b0;
            bit_cnt  <= '0;
        end else if (cs_fall) begin
            frame_rd <= start_rd;
            frame_wr <= ~start_rd;
            bit_cnt  <= '0;
        end else if (sclk_rise && (frame_rd || frame_wr)) begin
            bit_cnt <= bit_cnt + 1'b1;
            if (wr_done) frame_wr <= 1'b0;
            if (rd_done) frame_rd <= 1'b0;
        end
    end

    // Input word shifter, MSB first on rising serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n)                            in_word <= '0;
        else if (frame_wr && !cs_n_i && sclk_rise) in_word <= next_word[WORD_W-2:0];
    end

    // Mode, configuration and power-fail flag updates on a completed input word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_WATCH;
            cfg_q  <= '0;
            pf_q   <= 1'b1;
        end else if (wr_done && mode_known(new_mode)) begin
            mode_q <= mode_e'(new_mode);
            if (new_mode != mode_q)      pf_q  <= 1'b0;
            if (mode_takes_cfg(new_mode)) cfg_q <= next_word[CFG_W-1:0];
        end
    end

    // Status capture from the scanner and the pending interrupt, cleared by a completed read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q   <= '0;
            irq_pend <= 1'b1;
        end else if (stat_load_i) begin
            stat_q   <= stat_i;
            irq_pend <= 1'b1;
        end else if (rd_done) begin
            stat_q   <= '0;
            irq_pend <= 1'b0;
        end
    end

    assign do_o    = frame_rd & sh_bit;
    assign irq_n_o = ~(irq_pend & cs_seen);
    assign mode_o  = mode_q;
    assign cfg_o   = cfg_q;
endmodule

// File: rtl/msc_checker.sv
// Temporal checks for msc_top, attached through bind.
// Assumes: it is connected to the top's ports and a few framing registers.
module msc_checker #(
    parameter int PAIRS = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cs_n_i,
    input logic               do_o,
    input logic               irq_n_o,
    input logic               stat_load_i,
    input logic [3:0]         mode_o,
    input logic               pf_q,
    input logic               cs_seen,
    input logic               rd_done,
    input logic [2*PAIRS-1:0] chan_en_o,
    input logic [PAIRS-1:0]   pair_diff_o
);
    logic [PAIRS-1:0] diff_bad;

    // Flag any differential pair whose two channels are not both enabled.
    always_comb begin
        for (int g = 0; g < PAIRS; g++)
            diff_bad[g] = pair_diff_o[g] & (chan_en_o[2*g +: 2] != 2'b11);
    end

    a_r1_no_irq_before_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_seen |-> irq_n_o);
    a_r3_read_end_releases_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !stat_load_i) |=> irq_n_o);
    a_r4_load_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_load_i && cs_seen) |=> !irq_n_o);
    a_r2_do_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n_i && $past(cs_n_i)) |-> !do_o);
    a_r6_mode_moves_only_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> !$past(cs_n_i));
    a_r7_mode_always_defined: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 4'hA) || (mode_o == 4'h5) || (mode_o == 4'h3));
    a_r9_change_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_o) |-> !pf_q);
    a_r10_diff_needs_both: assert property (@(posedge clk) disable iff (!rst_n)
        diff_bad == '0);
endmodule

bind msc_top msc_checker #(.PAIRS(PAIRS)) chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n_i      (cs_n_i),
    .do_o        (do_o),
    .irq_n_o     (irq_n_o),
    .stat_load_i (stat_load_i),
    .mode_o      (mode_o),
    .pf_q        (pf_q),
    .cs_seen     (cs_seen),
    .rd_done     (rd_done),
    .chan_en_o   (chan_en_o),
    .pair_diff_o (pair_diff_o)
);

// File: tb/msc_top_test.sv
module msc_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cs_n = 1'b0, sclk = 1'b0, di = 1'b0, stat_load = 1'b0;
    logic [15:0] stat = '0;
    logic        dout, irq_n;
    logic [3:0]  mode;
    logic [11:0] cfg;
    logic [7:0]  en;
    logic [3:0]  diff, swap;
    int          total = 0, bad = 0;
    bit          done = 0;
    logic [16:0] rv;

    // word16, mode4, cfg12, en8, diff4, swap4
    localparam int NV = 5;
    localparam logic [47:0] VEC [NV] = '{
        {16'h59B4, 4'h5, 12'h9B4, 8'hD7, 4'h9, 4'h0},
        {16'hF123, 4'h5, 12'h9B4, 8'hD7, 4'h9, 4'h0},
        {16'h3777, 4'h3, 12'h9B4, 8'hD7, 4'h9, 4'h0},
        {16'hA5AC, 4'hA, 12'h5AC, 8'hDF, 4'h3, 4'h2},
        {16'hA0F1, 4'hA, 12'h0F1, 8'h34, 4'h0, 4'h0}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    msc_top uut (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .di_i(di),
        .do_o(dout), .irq_n_o(irq_n), .stat_load_i(stat_load), .stat_i(stat),
        .mode_o(mode), .cfg_o(cfg), .chan_en_o(en), .pair_diff_o(diff), .pair_swap_o(swap)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        cs_n = 1'b0; rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_read(input logic dval, output logic [16:0] val);
        cs_n = 1'b1;
        repeat (40) @(negedge clk);
        cs_n = 1'b0; di = dval;
        repeat (2) @(negedge clk);
        for (int i = 0; i < 17; i++) begin
            val[16-i] = dout;
            sclk = 1'b1; repeat (2) @(negedge clk);
            sclk = 1'b0; repeat (2) @(negedge clk);
        end
        cs_n = 1'b1; di = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic do_write(input logic [15:0] w, input int nbits);
        cs_n = 1'b1;
        repeat (4) @(negedge clk);
        cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            di = w[15-i];
            sclk = 1'b1; repeat (2) @(negedge clk);
            sclk = 1'b0; repeat (2) @(negedge clk);
        end
        cs_n = 1'b1; di = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog timeout");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state, interrupt held off while chip select stays low
        do_reset();
        check("R1 irq before cs high", irq_n, 1);
        check("R1 mode", mode, 4'hA);
        check("R1 cfg", cfg, 0);
        check("R1 enables", en, 0);
        cs_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 irq after cs high", irq_n, 0);

        // R2: first read after power-up, flag set
        do_read(1'b0, rv);
        check("R2 power-up stream", rv, 17'h00001);
        check("R3 irq released", irq_n, 1);

        // R4, R2, R5: status load, then read with DI held high
        stat = 16'hA5C3; stat_load = 1'b1;
        @(negedge clk);
        stat_load = 1'b0;
        @(negedge clk);
        check("R4 irq on load", irq_n, 0);
        do_read(1'b1, rv);
        check("R2 status order", rv, 17'h14B87);
        check("R5 long gap ignores DI", mode, 4'hA);
        check("R3 irq released after read", irq_n, 1);
        do_read(1'b0, rv);
        check("R3 status cleared", rv, 17'h00001);

        // R6, R10: short gap opens an input frame in watchdog mode
        do_write(16'hA0AF, 16);
        check("R6 mode after write", mode, 4'hA);
        check("R6 cfg after write", cfg, 12'h0AF);
        check("R10 enables", en, 8'h3E);
        check("R10 diff", diff, 4'h2);
        check("R10 swap", swap, 4'h2);
        // R9: same-mode rewrite keeps the flag
        do_read(1'b0, rv);
        check("R9 flag kept", rv, 17'h00001);

        // R6: truncated frame changes nothing
        do_write(16'h5123, 8);
        check("R6 truncated mode", mode, 4'hA);
        check("R6 truncated cfg", cfg, 12'h0AF);

        // R7, R8, R10: vector table
        for (int v = 0; v < NV; v++) begin
            do_write(VEC[v][47:32], 16);
            check("R7 mode", mode, VEC[v][31:28]);
            check("R8 cfg", cfg, VEC[v][27:16]);
            check("R10 en", en, VEC[v][15:8]);
            check("R10 diff", diff, VEC[v][7:4]);
            check("R10 swap", swap, VEC[v][3:0]);
        end

        // R9: mode changes cleared the flag
        do_read(1'b0, rv);
        check("R9 flag cleared", rv, 17'h00000);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule